// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is a single 8-bit data port that carries traffic in both directions over the same pins, paced by a two-wire handshake with an external device. The processor side writes bytes into an output holding register and reads bytes from an input holding register. The two registers are separate. The device side pulls an outgoing byte by asserting an acknowledge input, and it pushes an incoming byte by asserting a strobe input. The pins are released (high impedance) at all other times. The block drives the pins only while the acknowledge is held low.

Two flags report the handshake state. An active-low output-full flag says that a written byte has not yet been taken. An active-high input-full flag says that a captured byte has not yet been read. One interrupt request line merges an output-side event and an input-side event. Each side has its own enable bit, and the processor changes those bits with single-bit set/clear commands. The processor can also read a status byte that packs the flags, the enables and the request into fixed bit positions. The strobe, the acknowledge and the pin data arrive asynchronously. They are synchronized into the system clock domain, and every handshake edge is detected on those synchronized copies.

Top module: `bdp_port`

## Requirements
- R1: After reset the output-full flag is high (inactive), the input-full flag is low, the request is low, the pins are not driven, both enables are clear and the status byte reads 8'h80.
- R2: The pin drive enable is high exactly while the synchronized acknowledge is low, and during that time the pins carry the output register. A processor write on its own does not turn on the drive.
- R3: A write pulse loads the output register and drives the output-full flag low on the next clock. A synchronized falling acknowledge returns the flag high.
- R4: While the synchronized strobe is low, the pin data is copied into the input register, and the input-full flag rises on the strobe's falling edge. The register then holds its value after the strobe returns high. A read pulse clears the flag on the next clock.
- R5: When the output enable is set, a rising acknowledge that finds the output-full flag high raises the output event. A write clears the event.
- R6: When the input enable is set, a rising strobe that finds the input-full flag high raises the input event. A read clears the event.
- R7: A set/clear command with bit index 6 writes the output enable, and bit index 4 writes the input enable. Commands with any other index change neither enable.
- R8: The request line is the OR of the two events, and each event is gated by its own enable. Clearing an enable removes that event from the request even while the event is still pending.
- R9: The status byte is {output-full, output enable, input-full, input enable, request, 3'b000}. Bit 7 is output-full and bit 3 is the request.
- R10: A strobe capture while an output byte is pending does not change the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | One-cycle write pulse into the output register |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rd | input | 1 | One-cycle read pulse that consumes the input register |
| cpu_rdata | output | 8 | Input register contents |
| bsr_wr | input | 1 | One-cycle single-bit set/clear command |
| bsr_sel | input | 3 | Bit index of the command |
| bsr_val | input | 1 | Value to write (1 set, 0 clear) |
| status | output | 8 | Packed status byte |
| pin_in | input | 8 | Data arriving on the pins |
| pin_out | output | 8 | Data to drive on the pins |
| pin_oe | output | 1 | Pin drive enable |
| stb_n | input | 1 | Active-low strobe from the device |
| ack_n | input | 1 | Active-low acknowledge from the device |
| obf_n | output | 1 | Active-low output-full flag |
| ibf | output | 1 | Input-full flag |
| intr | output | 1 | Merged interrupt request |

## Verification
The bench sweeps all 256 byte values through the output handshake and all 256 through the input handshake, and it alternates the relevant enable on each pass. A design that drove the pins on a write, or that left them driven after the acknowledge, fails the drive checks. A design whose request ignored its enable, or was never cleared by the write or the read, shows a wrong request level. The bench also issues every set/clear index to catch an enable decoded from the wrong bit. It strobes the input while an output byte is pending, because a design with a shared register would drive the captured byte out of the pins. It clears the output enable while an output event is still pending, which separates a gated request from an ungated one.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    localparam int BSR_OUT_EN = 6;
    localparam int BSR_IN_EN  = 4;
    localparam int ST_OBF     = 7;
    localparam int ST_OUT_EN  = 6;
    localparam int ST_IBF     = 5;
    localparam int ST_IN_EN   = 4;
    localparam int ST_REQ     = 3;
    localparam int ST_W       = 8;
    localparam int SEL_W      = 3;
endpackage

// File: rtl/bdp_sync.sv
module bdp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stage_d;
        if (i == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = chain_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= stage_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bdp_out_chan.sv
module bdp_out_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          ack_s_n,
    input  logic          enable,
    output logic [DW-1:0] latch,
    output logic          full_n,
    output logic          req
);
    typedef struct packed {
        logic          ack_prev;
        logic [DW-1:0] data;
        logic          full_n;
        logic          pend;
    } out_state_t;

    out_state_t st_d, st_q;
    logic ack_fall, ack_rise;

    always_comb begin
        ack_fall = st_q.ack_prev & ~ack_s_n;
        ack_rise = ~st_q.ack_prev & ack_s_n;
        st_d = st_q;
        st_d.ack_prev = ack_s_n;
        if (wr) begin
            st_d.data   = wdata;
            st_d.full_n = 1'b0;
            st_d.pend   = 1'b0;
        end else begin
            if (ack_fall) st_d.full_n = 1'b1;
            if (ack_rise && st_q.full_n) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ack_prev <= 1'b1;
            st_q.data     <= '0;
            st_q.full_n   <= 1'b1;
            st_q.pend     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch  = st_q.data;
    assign full_n = st_q.full_n;
    assign req    = st_q.pend & enable;

    p_full_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !full_n);
    p_write_clears_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !req);
    p_release_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall && !wr) |=> full_n);
endmodule

// File: rtl/bdp_in_chan.sv
module bdp_in_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          stb_s_n,
    input  logic [DW-1:0] pin_s,
    input  logic          enable,
    output logic [DW-1:0] latch,
    output logic          full,
    output logic          req
);
    typedef struct packed {
        logic          stb_prev;
        logic [DW-1:0] data;
        logic          full;
        logic          pend;
    } in_state_t;

    in_state_t st_d, st_q;
    logic stb_fall, stb_rise;

    always_comb begin
        stb_fall = st_q.stb_prev & ~stb_s_n;
        stb_rise = ~st_q.stb_prev & stb_s_n;
        st_d = st_q;
        st_d.stb_prev = stb_s_n;
        if (!stb_s_n) st_d.data = pin_s;
        if (stb_fall) begin
            st_d.full = 1'b1;
        end else if (rd) begin
            st_d.full = 1'b0;
        end
        if (rd) begin
            st_d.pend = 1'b0;
        end else if (stb_rise && st_q.full) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stb_prev <= 1'b1;
            st_q.data     <= '0;
            st_q.full     <= 1'b0;
            st_q.pend     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch = st_q.data;
    assign full  = st_q.full;
    assign req   = st_q.pend & enable;

    p_full_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> full);
    p_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !stb_fall) |=> !full);
    p_read_clears_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !req);
endmodule

// File: rtl/bdp_port.sv
module bdp_port
    import bdp_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_rd,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             bsr_wr,
    input  logic [SEL_W-1:0] bsr_sel,
    input  logic             bsr_val,
    output logic [ST_W-1:0]  status,
    input  logic [DW-1:0]    pin_in,
    output logic [DW-1:0]    pin_out,
    output logic             pin_oe,
    input  logic             stb_n,
    input  logic             ack_n,
    output logic             obf_n,
    output logic             ibf,
    output logic             intr
);
    localparam int SW = DW + 2;

    typedef struct packed {
        logic out_en;
        logic in_en;
    } en_state_t;

    en_state_t en_d, en_q;
    logic [SW-1:0] sync_out;
    logic [DW-1:0] pin_s;
    logic          stb_s_n, ack_s_n;
    logic          out_req, in_req;

    bdp_sync #(
        .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({2'b11, {DW{1'b0}}})
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ack_n, stb_n, pin_in}),
        .sync_o(sync_out)
    );

    assign pin_s   = sync_out[DW-1:0];
    assign stb_s_n = sync_out[DW];
    assign ack_s_n = sync_out[DW+1];

    always_comb begin
        en_d = en_q;
        if (bsr_wr) begin
            if (bsr_sel == SEL_W'(BSR_OUT_EN)) en_d.out_en = bsr_val;
            if (bsr_sel == SEL_W'(BSR_IN_EN))  en_d.in_en  = bsr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    bdp_out_chan #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .wr(cpu_wr), .wdata(cpu_wdata),
        .ack_s_n(ack_s_n), .enable(en_q.out_en),
        .latch(pin_out), .full_n(obf_n), .req(out_req)
    );

    bdp_in_chan #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n),
        .rd(cpu_rd), .stb_s_n(stb_s_n), .pin_s(pin_s),
        .enable(en_q.in_en),
        .latch(cpu_rdata), .full(ibf), .req(in_req)
    );

    assign pin_oe = ~ack_s_n;
    assign intr   = out_req | in_req;

    always_comb begin
        status            = '0;
        status[ST_OBF]    = obf_n;
        status[ST_OUT_EN] = en_q.out_en;
        status[ST_IBF]    = ibf;
        status[ST_IN_EN]  = en_q.in_en;
        status[ST_REQ]    = intr;
    end

    p_request_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> (en_q.out_en || en_q.in_en));
    p_other_index_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bsr_wr && bsr_sel != SEL_W'(BSR_OUT_EN) && bsr_sel != SEL_W'(BSR_IN_EN))
        |=> (en_q == $past(en_q)));
    p_write_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && ack_n && ack_s_n && $past(ack_n)) |=> !pin_oe);
endmodule

// File: tb/sim_bdp_port.sv
module sim_bdp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, bsr_wr = 1'b0, bsr_val = 1'b0;
    logic [7:0] cpu_wdata = '0, pin_in = '0;
    logic [2:0] bsr_sel = '0;
    logic       stb_n = 1'b1, ack_n = 1'b1;
    logic [7:0] cpu_rdata, status, pin_out;
    logic       pin_oe, obf_n, ibf, intr;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bdp_port u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .bsr_wr(bsr_wr),
        .bsr_sel(bsr_sel), .bsr_val(bsr_val), .status(status),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .intr(intr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v;
        tick(1);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read();
        cpu_rd = 1'b1;
        tick(1);
        cpu_rd = 1'b0;
    endtask

    task automatic do_bsr(input int idx, input logic v);
        bsr_wr = 1'b1; bsr_sel = 3'(idx); bsr_val = v;
        tick(1);
        bsr_wr = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat(logic f_n, logic e1, logic f, logic e2, logic r);
        return {24'd0, f_n, e1, f, e2, r, 3'b000};
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 obf_n", obf_n, 1);
        chk("R1 ibf", ibf, 0);
        chk("R1 intr", intr, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 status", status, 32'h80);

        // R7 every set/clear index
        for (int b = 0; b < 8; b++) begin
            do_bsr(b, 1'b1);
            chk("R7 out enable", status[6], (b == 6));
            chk("R7 in enable", status[4], (b == 4));
            do_bsr(6, 1'b0);
            do_bsr(4, 1'b0);
        end

        // Output sweep: R2 R3 R5 R9
        for (int v = 0; v < 256; v++) begin
            logic e1;
            e1 = v[0];
            do_bsr(6, e1);
            do_write(8'(v));
            chk("R3 obf_n after write", obf_n, 0);
            chk("R2 no drive on write", pin_oe, 0);
            chk("R5 write clears event", intr, 0);
            ack_n = 1'b0; tick(4);
            chk("R2 drive during ack", pin_oe, 1);
            chk("R2 pin data", pin_out, 32'(v));
            chk("R3 obf_n after ack", obf_n, 1);
            ack_n = 1'b1; tick(4);
            chk("R2 release after ack", pin_oe, 0);
            chk("R5 output event", intr, 32'(e1));
            chk("R9 status out", status, exp_stat(1'b1, e1, 1'b0, 1'b0, e1));
        end

        // R8 clearing enable masks a pending event
        chk("R8 pending before clear", intr, 1);
        do_bsr(6, 1'b0);
        chk("R8 masked by enable", intr, 0);
        do_bsr(6, 1'b1);
        chk("R8 unmasked again", intr, 1);
        do_bsr(6, 1'b0);

        // Input sweep: R4 R6 R9
        for (int v = 0; v < 256; v++) begin
            logic e2;
            e2 = v[0];
            do_bsr(4, e2);
            pin_in = 8'(v);
            stb_n = 1'b0; tick(4);
            chk("R4 ibf on strobe", ibf, 1);
            chk("R4 captured", cpu_rdata, 32'(v));
            chk("R6 no event while low", intr, 0);
            stb_n = 1'b1; tick(4);
            pin_in = ~8'(v); tick(4);
            chk("R4 held after strobe", cpu_rdata, 32'(v));
            chk("R6 input event", intr, 32'(e2));
            chk("R9 status in", status, exp_stat(1'b1, 1'b0, 1'b1, e2, e2));
            do_read();
            chk("R4 read empties", ibf, 0);
            chk("R6 read clears event", intr, 0);
        end

        // R10 strobe while output pending
        do_write(8'hA5);
        pin_in = 8'h5A;
        stb_n = 1'b0; tick(4);
        stb_n = 1'b1; tick(4);
        chk("R10 out reg untouched", pin_out, 32'hA5);
        chk("R10 in reg", cpu_rdata, 32'h5A);
        chk("R10 obf still pending", obf_n, 0);
        ack_n = 1'b0; tick(4);
        chk("R10 pins carry output", pin_out, 32'hA5);
        chk("R2 drive R10 case", pin_oe, 1);
        ack_n = 1'b1; tick(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule